// File: doc/BRIEF.md
# Serial Host Configuration Port

This block is a slave port on a four-wire serial link: an active-low chip select frames the transfer, a serial clock paces it, and data enters and leaves on separate lines. The host uses it to write a small control register and to read that register back or read a one-bit status flag. All serial pins are sampled by the block's own system clock, which must run several times faster than the serial clock. Edges of the serial clock are detected inside the block.

A frame is exactly sixteen serial clocks long. The input line is sampled on rising serial-clock edges and the output line changes on falling edges. The header holds a read/write flag, a five-bit address sent least significant bit first, a reserved bit that must be zero and a don't-care bit. The data byte follows, also least significant bit first. Two strap inputs give the device a channel number, and the two upper address bits must match it. The six control bits are driven out to the logic they configure. A line-rate mode is decoded from two of those bits. The output line has an enable, so the pad can present high impedance outside the read window and the host may join the two data lines.

Top module: `cfg_serial_port`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `ctrl_out` is 0, `sdo_oe` is 0 and `line_mode` is 0 (DS3). Pulling `rst_n` low clears `ctrl_out`.
- R2: With `cs_n` low, `sdi` is taken on each rising `sclk` edge. Frame bit 1 is the direction flag (1 = read, 0 = write). Bits 2 to 6 are address bits A0 to A4. Bit 7 is reserved and bit 8 is ignored. Bits 9 to 16 are data bits D0 to D7.
- R3: A write frame addressed to the control register loads D5..D0 into `ctrl_out[5:0]` after the sixteenth rising edge. The control register is selected by A2..A0 = 110 with a valid channel. D7..D6 are discarded. The fields are `ctrl_out[0]` FIFO depth select, [1] clock edge select, [2] bandwidth select, [3] attenuator disable, [4] E3 select and [5] STS-1 select.
- R4: On a valid read, `sdo_oe` rises after the falling edge that follows rising edge 8. `sdo` carries D0 at that point, then one more bit per falling edge until D7 after falling edge 15. `sdo_oe` drops after falling edge 16.
- R5: Reading the control register returns {00, ctrl_out}. Reading the status register (A2..A0 = 111) returns 0000000 followed by `limit_flag` in D0, where `limit_flag` is taken at falling edge 8.
- R6: A write frame addressed to the status register leaves `ctrl_out` unchanged.
- R7: A frame with bit 7 set, with A4..A3 not equal to `chan_strap`, or with `chan_strap` = 11 neither writes nor drives `sdo_oe`.
- R8: If `cs_n` rises before the sixteenth rising edge, the frame is aborted. Nothing is written, and `sdo_oe` is 0 from the next system clock.
- R9: `line_mode` decodes {`ctrl_out[5]`,`ctrl_out[4]`} as follows: 00 gives 0 (DS3), 01 and 11 give 1 (E3), and 10 gives 2 (STS-1).
- R10: `sdo` changes only in the system clock after a detected falling `sclk` edge. `ctrl_out` changes only as the result of a completed valid write frame, or of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| chan_strap | input | 2 | Channel number from strap pins |
| limit_flag | input | 1 | Buffer limit flag reported in status D0 |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| ctrl_out | output | 6 | Control register contents |
| line_mode | output | 2 | Decoded line-rate mode |

## Verification
On every system clock, the bound checker confirms several rules. The output enable falls whenever the chip select is high. The enable and the read bit move only after a detected falling serial edge. The control register changes only one clock after a completed write is flagged. The mode decode agrees with the two select bits. Other behaviour can only be shown by the bench's scenarios. These are the bit ordering of address and data, the returned read values, channel matching for each strap setting, rejection of the reserved bit, writes to the read-only address, and aborted frames. In those scenarios the bench drives whole frames and compares the outputs on every clock against its own model.

// File: rtl/cfgsp_pkg.sv
`timescale 1ns/1ps
package cfgsp_pkg;
  localparam int FRAME_BITS = 16;
  localparam int HDR_BITS   = 8;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int CTRL_W     = 6;

  typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_CTRL = 2'd1, TGT_STAT = 2'd2} tgt_e;
  typedef enum logic [1:0] {MODE_DS3 = 2'd0, MODE_E3 = 2'd1, MODE_STS1 = 2'd2} mode_e;

  // Register targeted by a header; NONE when reserved bit or channel fails.
  function automatic tgt_e decode_target(logic [ADDR_W-1:0] addr, logic rsvd,
                                         logic [1:0] strap);
    if (rsvd || addr[4:3] == 2'b11 || addr[4:3] != strap) return TGT_NONE;
    case (addr[2:0])
      3'b110:  return TGT_CTRL;
      3'b111:  return TGT_STAT;
      default: return TGT_NONE;
    endcase
  endfunction

  // E3 select wins over STS-1 select.
  function automatic mode_e decode_mode(logic sts1_sel, logic e3_sel);
    if (e3_sel)   return MODE_E3;
    if (sts1_sel) return MODE_STS1;
    return MODE_DS3;
  endfunction
endpackage

// File: rtl/cfgsp_frame.sv
`timescale 1ns/1ps
module cfgsp_frame #(
  parameter int FRAME_BITS = cfgsp_pkg::FRAME_BITS,
  localparam int CNT_W = $clog2(FRAME_BITS + 1),
  localparam int IDX_W = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk_rise,
  input  logic                  sdi,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic [FRAME_BITS-1:0] frame_bits,
  output logic                  frame_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      frame_bits <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (cs_n) begin
        bit_cnt <= '0;
      end else if (sclk_rise && bit_cnt < CNT_W'(FRAME_BITS)) begin
        frame_bits[bit_cnt[IDX_W-1:0]] <= sdi;
        bit_cnt    <= bit_cnt + 1'b1;
        frame_done <= (bit_cnt == CNT_W'(FRAME_BITS - 1));
      end
    end
  end
endmodule

// File: rtl/cfgsp_regs.sv
`timescale 1ns/1ps
module cfgsp_regs #(
  parameter int CTRL_W = cfgsp_pkg::CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [1:0]        line_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  assign line_mode = cfgsp_pkg::decode_mode(ctrl_q[CTRL_W-1], ctrl_q[CTRL_W-2]);
endmodule

// File: rtl/cfgsp_dout.sv
`timescale 1ns/1ps
module cfgsp_dout #(
  parameter int DATA_W     = cfgsp_pkg::DATA_W,
  parameter int HDR_BITS   = cfgsp_pkg::HDR_BITS,
  parameter int FRAME_BITS = cfgsp_pkg::FRAME_BITS,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] rd_value,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
      shreg  <= '0;
    end else if (cs_n) begin
      sdo_oe <= 1'b0;
    end else if (sclk_fall) begin
      if (bit_cnt == CNT_W'(HDR_BITS) && rd_ok) begin
        sdo_oe <= 1'b1;
        sdo    <= rd_value[0];
        shreg  <= rd_value >> 1;
      end else if (bit_cnt == CNT_W'(FRAME_BITS)) begin
        sdo_oe <= 1'b0;
      end else if (sdo_oe) begin
        sdo   <= shreg[0];
        shreg <= shreg >> 1;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
`timescale 1ns/1ps
module cfg_serial_port
  import cfgsp_pkg::*;
#(
  parameter int FRAME_BITS = cfgsp_pkg::FRAME_BITS,
  parameter int HDR_BITS   = cfgsp_pkg::HDR_BITS,
  parameter int DATA_W     = cfgsp_pkg::DATA_W,
  parameter int CTRL_W     = cfgsp_pkg::CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic [1:0]        chan_strap,
  input  logic              limit_flag,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [1:0]        line_mode
);
  localparam int CNT_W    = $clog2(FRAME_BITS + 1);
  localparam int RW_POS   = 0;
  localparam int ADDR_LO  = 1;
  localparam int RSVD_POS = ADDR_LO + ADDR_W;
  localparam int IGN_POS  = RSVD_POS + 1;

  logic                  sclk_q;
  logic                  sclk_rise, sclk_fall;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] frame_bits;
  logic                  frame_done;
  logic                  hdr_rw;
  logic [ADDR_W-1:0]     hdr_addr;
  tgt_e                  target;
  logic                  rd_ok, wr_commit;
  logic [DATA_W-1:0]     rd_value, wr_byte;
  logic                  ign_bit_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign sclk_rise = ~cs_n & sclk & ~sclk_q;
  assign sclk_fall = ~cs_n & ~sclk & sclk_q;

  cfgsp_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise), .sdi(sdi),
    .bit_cnt(bit_cnt), .frame_bits(frame_bits), .frame_done(frame_done)
  );

  assign hdr_rw         = frame_bits[RW_POS];
  assign hdr_addr       = frame_bits[ADDR_LO +: ADDR_W];
  assign wr_byte        = frame_bits[HDR_BITS +: DATA_W];
  assign ign_bit_unused = frame_bits[IGN_POS];
  assign target         = decode_target(hdr_addr, frame_bits[RSVD_POS], chan_strap);
  assign rd_ok          = hdr_rw && (target != TGT_NONE);
  assign wr_commit      = frame_done && !hdr_rw && (target == TGT_CTRL);
  assign rd_value       = (target == TGT_CTRL) ? {{(DATA_W-CTRL_W){1'b0}}, ctrl_out}
                                               : {{(DATA_W-1){1'b0}}, limit_flag};

  cfgsp_regs #(.CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .wr_data(wr_byte[CTRL_W-1:0]),
    .ctrl_q(ctrl_out), .line_mode(line_mode)
  );

  cfgsp_dout #(.DATA_W(DATA_W), .HDR_BITS(HDR_BITS), .FRAME_BITS(FRAME_BITS)) u_dout (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall), .bit_cnt(bit_cnt),
    .rd_ok(rd_ok), .rd_value(rd_value), .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: rtl/cfgsp_chk.sv
`timescale 1ns/1ps
module cfgsp_chk #(
  parameter int CTRL_W = cfgsp_pkg::CTRL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdo,
  input logic              sdo_oe,
  input logic [CTRL_W-1:0] ctrl_out,
  input logic [1:0]        line_mode,
  input logic              sclk_fall,
  input logic              wr_commit
);
  // R8
  csn_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);
  // R4
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(sclk_fall));
  // R4
  oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> $past(sclk_fall || cs_n));
  // R10
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sclk_fall));
  // R10
  ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_out) |-> $past(wr_commit));
  // R9
  mode_e3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out[CTRL_W-2] |-> line_mode == 2'd1);
  // R9
  mode_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_out[CTRL_W-1:CTRL_W-2] == 2'b10) |-> line_mode == 2'd2);
  // R9
  mode_ds3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_out[CTRL_W-1:CTRL_W-2] == 2'b00) |-> line_mode == 2'd0);
endmodule

bind cfg_serial_port cfgsp_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .ctrl_out(ctrl_out), .line_mode(line_mode), .sclk_fall(sclk_fall),
  .wr_commit(wr_commit)
);

// File: tb/cfg_serial_port_test.sv
`timescale 1ns/1ps
module cfg_serial_port_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, limit_flag = 1'b0;
  logic [1:0] chan_strap = 2'b00;
  logic       sdo, sdo_oe;
  logic [5:0] ctrl_out;
  logic [1:0] line_mode;

  int   checks = 0, errors = 0;
  logic [5:0] exp_ctrl = 6'd0;
  logic exp_oe = 1'b0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;

  cfg_serial_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .chan_strap(chan_strap), .limit_flag(limit_flag), .sdo(sdo), .sdo_oe(sdo_oe),
    .ctrl_out(ctrl_out), .line_mode(line_mode)
  );

  function automatic logic [31:0] ref_mode(logic [5:0] c);
    if (c[4]) return 1;
    if (c[5]) return 2;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference model
  always @(negedge clk) begin
    if (mon_en && !done) begin
      check("R10 ctrl_out", 32'(ctrl_out), 32'(exp_ctrl));
      check("R9 line_mode", 32'(line_mode), ref_mode(exp_ctrl));
      check("R4 sdo_oe", 32'(sdo_oe), 32'(exp_oe));
    end
  end

  task automatic do_frame(input bit rw, input logic [4:0] addr, input bit b7, input bit b8,
                          input logic [7:0] data, input int abort_at, input string tag);
    logic [15:0] fb;
    logic [7:0]  rbits, exp_r;
    bit ok, is_ctrl, is_stat, wr_ok, rd_ok, aborted;
    ok      = !b7 && (chan_strap != 2'b11) && ((addr >> 3) == 5'(chan_strap));
    is_ctrl = ok && (addr % 8 == 6);
    is_stat = ok && (addr % 8 == 7);
    wr_ok   = !rw && is_ctrl;
    rd_ok   = rw && (is_ctrl || is_stat);
    exp_r   = is_ctrl ? {2'b00, exp_ctrl} : {7'd0, limit_flag};
    fb      = {data, b8, b7, addr, rw};
    rbits   = 8'd0;
    aborted = 1'b0;
    @(posedge clk); #5 cs_n = 1'b0;
    for (int i = 1; i <= 16; i++) begin
      if (i == abort_at) begin
        @(posedge clk); #5 cs_n = 1'b1;
        @(posedge clk); #1 exp_oe = 1'b0;
        aborted = 1'b1;
        break;
      end
      @(posedge clk); #5 sdi = fb[i-1];
      @(posedge clk); #5 sclk = 1'b1;
      @(posedge clk);
      @(posedge clk); #1 if (i == 16 && wr_ok) exp_ctrl = data[5:0];
      #4 sclk = 1'b0;
      @(posedge clk); #1;
      if (i == 8 && rd_ok) exp_oe = 1'b1;
      if (i == 16) exp_oe = 1'b0;
      if (i >= 8 && i <= 15 && exp_oe) rbits[i-8] = sdo;
    end
    if (!aborted) begin
      @(posedge clk); #5 cs_n = 1'b1; sdi = 1'b0;
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
    if (rd_ok && !aborted) check({tag, " read data"}, 32'(rbits), 32'(exp_r));
    check({tag, " ctrl after frame"}, 32'(ctrl_out), 32'(exp_ctrl));
    check({tag, " oe idle"}, 32'(sdo_oe), 32'd0);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    check("R1 ctrl in reset", 32'(ctrl_out), 32'd0);
    check("R1 oe in reset", 32'(sdo_oe), 32'd0);
    check("R1 mode in reset", 32'(line_mode), 32'd0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (2) @(posedge clk);

    // R2 R3 R9: write 0x2B, bit 8 set (ignored) -> STS-1
    do_frame(1'b0, 5'h06, 1'b0, 1'b1, 8'h2B, 0, "R2 R3 write ctrl");
    check("R9 STS-1 mode", 32'(line_mode), 32'd2);
    // R4 R5: read back control
    do_frame(1'b1, 5'h06, 1'b0, 1'b0, 8'h00, 0, "R4 R5 read ctrl");
    // R3: upper data bits dropped, E3 select
    do_frame(1'b0, 5'h06, 1'b0, 1'b0, 8'hD5, 0, "R3 write D7:D6 dropped");
    check("R3 ctrl value", 32'(ctrl_out), 32'h15);
    do_frame(1'b1, 5'h06, 1'b0, 1'b1, 8'hFF, 0, "R5 read ctrl 2");
    // R5: status register
    limit_flag = 1'b1;
    do_frame(1'b1, 5'h07, 1'b0, 1'b0, 8'h00, 0, "R5 status flag set");
    limit_flag = 1'b0;
    do_frame(1'b1, 5'h07, 1'b0, 1'b0, 8'h00, 0, "R5 status flag clear");
    // R6: write to status leaves control alone
    do_frame(1'b0, 5'h07, 1'b0, 1'b0, 8'h3F, 0, "R6 write status");
    do_frame(1'b1, 5'h06, 1'b0, 1'b0, 8'h00, 0, "R6 readback");
    // R7: reserved bit set
    do_frame(1'b0, 5'h06, 1'b1, 1'b0, 8'h00, 0, "R7 rsvd write");
    do_frame(1'b1, 5'h06, 1'b1, 1'b0, 8'h00, 0, "R7 rsvd read");
    // R7: channel strap 01
    chan_strap = 2'b01;
    do_frame(1'b0, 5'h06, 1'b0, 1'b0, 8'h00, 0, "R7 channel mismatch");
    do_frame(1'b0, 5'h0E, 1'b0, 1'b0, 8'h30, 0, "R3 channel 1 write");
    check("R9 both selects give E3", 32'(line_mode), 32'd1);
    do_frame(1'b1, 5'h0E, 1'b0, 1'b0, 8'h00, 0, "R5 channel 1 read");
    chan_strap = 2'b10;
    do_frame(1'b0, 5'h16, 1'b0, 1'b0, 8'h0A, 0, "R3 channel 2 write");
    check("R9 DS3 mode", 32'(line_mode), 32'd0);
    chan_strap = 2'b11;
    do_frame(1'b0, 5'h1E, 1'b0, 1'b0, 8'h3F, 0, "R7 strap 11 write");
    do_frame(1'b1, 5'h1F, 1'b0, 1'b0, 8'h00, 0, "R7 strap 11 read");
    chan_strap = 2'b00;
    // R8: aborted write and aborted read
    do_frame(1'b0, 5'h06, 1'b0, 1'b0, 8'h21, 12, "R8 abort write");
    do_frame(1'b0, 5'h06, 1'b0, 1'b0, 8'h21, 16, "R8 abort before last");
    do_frame(1'b1, 5'h06, 1'b0, 1'b0, 8'h00, 12, "R8 abort read");
    check("R8 ctrl kept", 32'(ctrl_out), 32'h0A);
    // R1: reset clears control
    do_frame(1'b0, 5'h06, 1'b0, 1'b0, 8'h3C, 0, "R3 write before reset");
    @(posedge clk); #5 rst_n = 1'b0; exp_ctrl = 6'd0;
    @(posedge clk); #5;
    check("R1 ctrl cleared", 32'(ctrl_out), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    do_frame(1'b1, 5'h06, 1'b0, 1'b0, 8'h00, 0, "R1 read after reset");
    summary();
  end
endmodule